// File: doc/BRIEF.md
# DMA Channel Address Window Decoder

This block takes a 58-bit system address and works out which DMA channel register window it falls in. It finds the cluster region the address lies in, then the channel slot inside that region. The slot offset is then matched against the fixed engine windows. The result is a cluster id, a channel index, a one-hot engine select and the byte offset inside the selected engine window. The die bit and the privileged-aperture bit are also reported.

Each address is classed as a normal hit, a broadcast-mirror hit, a reserved-hole hit or an unmapped miss. A front-end that steers configuration writes to per-channel register blocks, or a monitor that labels bus traffic, can use the result directly.

The decode path is purely combinational. One register stage sits in front of the outputs, so each strobed address yields exactly one result on the following cycle. There is no back-pressure.

Top module: `dma_win_decode`

## Requirements
- R1: `o_vld` equals `i_vld` from the previous clock, with no back-pressure. Reset clears `o_vld` and every result field to zero.
- R2: In a cycle with `i_vld` low, all result fields keep the values of the last strobed address.
- R3: `o_die` reports address bit 47 and `o_priv` reports bit 53 for every strobed address. Bits 48–52 and 54–57 have no effect on any output. On a hit, `o_cluster` is {bit 47, bit 38}.
- R4: The local offset is bits [46:0]. It must fall inside a cluster region of 0xC800000 bytes. The region starts at 0x1000000000 when bit 38 is 0 and at 0x5000000000 when bit 38 is 1. Any other local offset is a miss.
- R5: The 32 channel slots of 0x100000 bytes each begin at region offset 0x2000000 in even clusters (bit 38 = 0) and at 0x4000000 in odd clusters. `o_chan` is the slot index. A region offset outside this group is a miss.
- R6: Engine windows sit at fixed slot offsets. Each maps to one `o_eng` bit: bit0 outbound at 0x00000 (0x20000 bytes), bit1 inbound at 0x20000 (0x18000), bit2 general at 0x38000 (0x4000), bit3 general-extended at 0x3C000 (0x4000), bit4 app-glue at 0x40000 (0x1000), bit5 notification at 0x41000 (0x1000). `o_off` (17 bits) is the slot offset minus the window start.
- R7: Slot offsets 0x42000–0x43FFF raise both `o_rsvd` and `o_miss`.
- R8: Slot offsets 0x44000–0x7FFFF, and 0xC0000–0xFFFFF, are misses with `o_rsvd` low.
- R9: In channels 0 and 16 only, slot offsets 0x80000–0xBFFFF hit a mirror. The mirror holds the outbound, inbound, general and general-extended windows, laid out as in R6 starting at 0x80000. Such a hit raises `o_bcast`, and `o_off` is relative to the mirrored window start.
- R10: In any other channel, slot offsets 0x80000–0xBFFFF are misses.
- R11: On a miss, `o_eng`, `o_off`, `o_chan`, `o_cluster` and `o_bcast` are all zero. A non-miss always has exactly one `o_eng` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_vld | input | 1 | Address strobe |
| i_addr | input | 58 | System address |
| o_vld | output | 1 | Result valid, one cycle after `i_vld` |
| o_cluster | output | 2 | {die, cluster parity} on a hit |
| o_die | output | 1 | Address bit 47 |
| o_priv | output | 1 | Address bit 53 |
| o_chan | output | 5 | Channel slot index |
| o_eng | output | 6 | One-hot engine select |
| o_off | output | 17 | Offset inside the engine window |
| o_bcast | output | 1 | Broadcast-mirror hit |
| o_rsvd | output | 1 | Reserved-hole hit |
| o_miss | output | 1 | No engine window matched |

## Verification
Each result is a pure function of one registered address, so a wrong decode shows at the ports on the very next cycle. The visible signs are a misplaced one-hot bit, a shifted offset or a missing miss flag. Faults hide at the window edges, so the stimulus lands on the first and last byte of every window. It also probes the parity-dependent channel group, the reserved hole, and the mirror range on both broadcast channels and on ordinary channels. A broken hold path shows up in the first idle cycle after a strobe, as fields that change without a new address.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;

    localparam int ADDR_W         = 58;
    localparam int LOCAL_W        = 47;
    localparam int DIE_BIT        = 47;
    localparam int PRIV_BIT       = 53;
    localparam int PARITY_BIT     = 38;
    localparam int NUM_CH         = 32;
    localparam int CH_W           = $clog2(NUM_CH);
    localparam int SLOT_W         = 20;
    localparam int OFF_W          = 17;
    localparam int NUM_ENG        = 6;
    localparam int NUM_MIRROR_ENG = 4;
    localparam int CLUSTER_W      = 2;
    localparam int MIRROR_CH_A    = 0;
    localparam int MIRROR_CH_B    = 16;

    localparam logic [LOCAL_W-1:0] REGION_BASE_EVEN = 47'h10_0000_0000;
    localparam logic [LOCAL_W-1:0] PARITY_MASK      = LOCAL_W'(1) << PARITY_BIT;
    localparam logic [LOCAL_W-1:0] REGION_SPAN      = 47'h0C80_0000;
    localparam logic [LOCAL_W-1:0] GROUP_OFF_EVEN   = 47'h0200_0000;
    localparam logic [LOCAL_W-1:0] GROUP_OFF_ODD    = 47'h0400_0000;
    localparam logic [LOCAL_W-1:0] SLOT_SIZE        = LOCAL_W'(1) << SLOT_W;
    localparam logic [LOCAL_W-1:0] GROUP_SPAN       = SLOT_SIZE * LOCAL_W'(NUM_CH);

    localparam logic [SLOT_W:0] MIRROR_OFF = 21'h8_0000;
    localparam logic [SLOT_W:0] HOLE_BASE  = 21'h4_2000;
    localparam logic [SLOT_W:0] HOLE_SIZE  = 21'h0_2000;

    // engine index doubles as the one-hot bit position
    typedef enum logic [2:0] {
        ENG_OUT, ENG_IN, ENG_GEN, ENG_GENX, ENG_APP, ENG_NOTI
    } eng_e;

    function automatic logic [SLOT_W:0] win_base(input int idx);
        case (idx)
            ENG_OUT:  return 21'h0_0000;
            ENG_IN:   return 21'h2_0000;
            ENG_GEN:  return 21'h3_8000;
            ENG_GENX: return 21'h3_C000;
            ENG_APP:  return 21'h4_0000;
            default:  return 21'h4_1000;
        endcase
    endfunction

    function automatic logic [SLOT_W:0] win_size(input int idx);
        case (idx)
            ENG_OUT:  return 21'h2_0000;
            ENG_IN:   return 21'h1_8000;
            ENG_GEN:  return 21'h0_4000;
            ENG_GENX: return 21'h0_4000;
            default:  return 21'h0_1000;
        endcase
    endfunction

    typedef struct packed {
        logic              hit;
        logic              parity;
        logic [CH_W-1:0]   chan;
        logic [SLOT_W-1:0] slot;
    } region_t;

    typedef struct packed {
        logic [NUM_ENG-1:0] eng;
        logic [OFF_W-1:0]   off;
        logic               bcast;
        logic               rsvd;
    } slot_t;

    typedef struct packed {
        logic [CLUSTER_W-1:0] cluster;
        logic                 die;
        logic                 priv;
        logic [CH_W-1:0]      chan;
        logic [NUM_ENG-1:0]   eng;
        logic [OFF_W-1:0]     off;
        logic                 bcast;
        logic                 rsvd;
        logic                 miss;
    } result_t;

endpackage

// File: rtl/dmadec_region.sv
module dmadec_region
    import dmadec_pkg::*;
(
    input  logic [LOCAL_W-1:0] i_local,
    output region_t            o_region
);
    logic               parity;
    logic [LOCAL_W-1:0] base;
    logic [LOCAL_W-1:0] roff;
    logic [LOCAL_W-1:0] grp_off;
    logic [LOCAL_W-1:0] rel;
    logic               in_region;
    logic               in_group;
    logic               rel_unused;

    always_comb begin
        parity    = i_local[PARITY_BIT];
        base      = parity ? (REGION_BASE_EVEN | PARITY_MASK) : REGION_BASE_EVEN;
        roff      = i_local - base;
        in_region = (i_local >= base) && (roff < REGION_SPAN);
        grp_off   = parity ? GROUP_OFF_ODD : GROUP_OFF_EVEN;
        rel       = roff - grp_off;
        in_group  = (roff >= grp_off) && (rel < GROUP_SPAN);
    end

    assign rel_unused      = ^rel[LOCAL_W-1:SLOT_W+CH_W];
    assign o_region.hit    = in_region && in_group;
    assign o_region.parity = parity;
    assign o_region.chan   = rel[SLOT_W +: CH_W];
    assign o_region.slot   = rel[SLOT_W-1:0];
endmodule

// File: rtl/dmadec_slot.sv
module dmadec_slot
    import dmadec_pkg::*;
(
    input  logic [SLOT_W-1:0] i_slot,
    input  logic              i_mirror_ok,
    output slot_t             o_slot
);
    logic [SLOT_W:0]         s;
    logic [NUM_ENG-1:0]      hit_u;
    logic [NUM_MIRROR_ENG-1:0] hit_m;
    logic [OFF_W-1:0]        off_u [NUM_ENG];
    logic [OFF_W-1:0]        off_m [NUM_MIRROR_ENG];

    assign s = {1'b0, i_slot};

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_unicast
        localparam logic [SLOT_W:0] B = win_base(g);
        localparam logic [SLOT_W:0] E = win_base(g) + win_size(g);
        logic [SLOT_W:0] d;
        assign d        = s - B;
        assign hit_u[g] = (s >= B) && (s < E);
        assign off_u[g] = d[OFF_W-1:0];
    end

    for (genvar g = 0; g < NUM_MIRROR_ENG; g++) begin : g_mirror
        localparam logic [SLOT_W:0] B = win_base(g) + MIRROR_OFF;
        localparam logic [SLOT_W:0] E = win_base(g) + win_size(g) + MIRROR_OFF;
        logic [SLOT_W:0] d;
        assign d        = s - B;
        assign hit_m[g] = i_mirror_ok && (s >= B) && (s < E);
        assign off_m[g] = d[OFF_W-1:0];
    end

    // windows are disjoint, so at most one term contributes
    always_comb begin
        o_slot = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (hit_u[i]) begin
                o_slot.eng[i] = 1'b1;
                o_slot.off    = o_slot.off | off_u[i];
            end
        end
        for (int i = 0; i < NUM_MIRROR_ENG; i++) begin
            if (hit_m[i]) begin
                o_slot.eng[i] = 1'b1;
                o_slot.off    = o_slot.off | off_m[i];
                o_slot.bcast  = 1'b1;
            end
        end
        o_slot.rsvd = (s >= HOLE_BASE) && (s < HOLE_BASE + HOLE_SIZE);
    end
endmodule

// File: rtl/dmadec_outreg.sv
module dmadec_outreg
    import dmadec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    i_vld,
    input  result_t i_res,
    output logic    o_vld,
    output result_t o_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
            o_res <= '0;
        end else begin
            o_vld <= i_vld;
            if (i_vld) begin
                o_res <= i_res;
            end
        end
    end
endmodule

// File: rtl/dma_win_decode.sv
module dma_win_decode
    import dmadec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_vld,
    input  logic [ADDR_W-1:0]    i_addr,
    output logic                 o_vld,
    output logic [CLUSTER_W-1:0] o_cluster,
    output logic                 o_die,
    output logic                 o_priv,
    output logic [CH_W-1:0]      o_chan,
    output logic [NUM_ENG-1:0]   o_eng,
    output logic [OFF_W-1:0]     o_off,
    output logic                 o_bcast,
    output logic                 o_rsvd,
    output logic                 o_miss
);
    region_t region;
    slot_t   slot;
    result_t res_d;
    result_t res_q;
    logic    mirror_ok;
    logic    win_hit;
    logic    attr_unused;

    assign attr_unused = ^{i_addr[PRIV_BIT-1:DIE_BIT+1], i_addr[ADDR_W-1:PRIV_BIT+1]};

    dmadec_region u_region (
        .i_local  (i_addr[LOCAL_W-1:0]),
        .o_region (region)
    );

    assign mirror_ok = (region.chan == CH_W'(MIRROR_CH_A)) ||
                       (region.chan == CH_W'(MIRROR_CH_B));

    dmadec_slot u_slot (
        .i_slot      (region.slot),
        .i_mirror_ok (mirror_ok),
        .o_slot      (slot)
    );

    assign win_hit = region.hit && (|slot.eng);

    always_comb begin
        res_d      = '0;
        res_d.die  = i_addr[DIE_BIT];
        res_d.priv = i_addr[PRIV_BIT];
        res_d.rsvd = region.hit && slot.rsvd;
        res_d.miss = !win_hit;
        if (win_hit) begin
            res_d.cluster = {i_addr[DIE_BIT], region.parity};
            res_d.chan    = region.chan;
            res_d.eng     = slot.eng;
            res_d.off     = slot.off;
            res_d.bcast   = slot.bcast;
        end
    end

    dmadec_outreg u_outreg (
        .clk   (clk),
        .rst   (rst),
        .i_vld (i_vld),
        .i_res (res_d),
        .o_vld (o_vld),
        .o_res (res_q)
    );

    assign o_cluster = res_q.cluster;
    assign o_die     = res_q.die;
    assign o_priv    = res_q.priv;
    assign o_chan    = res_q.chan;
    assign o_eng     = res_q.eng;
    assign o_off     = res_q.off;
    assign o_bcast   = res_q.bcast;
    assign o_rsvd    = res_q.rsvd;
    assign o_miss    = res_q.miss;

    a_r1_vld_follows: assert property (@(posedge clk) disable iff (rst)
        i_vld |=> o_vld);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !i_vld |=> !o_vld);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !i_vld |=> ($stable(o_eng) && $stable(o_off) && $stable(o_chan) && $stable(o_miss)));
    a_r3_die_priv: assert property (@(posedge clk) disable iff (rst)
        i_vld |=> (o_die == $past(i_addr[DIE_BIT]) && o_priv == $past(i_addr[PRIV_BIT])));
    a_r7_rsvd_is_miss: assert property (@(posedge clk) disable iff (rst)
        (o_vld && o_rsvd) |-> o_miss);
    a_r9_bcast_chan: assert property (@(posedge clk) disable iff (rst)
        (o_vld && o_bcast) |-> ((o_chan == CH_W'(MIRROR_CH_A) || o_chan == CH_W'(MIRROR_CH_B))
                                && o_eng[NUM_ENG-1:NUM_MIRROR_ENG] == '0));
    a_r11_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (o_vld && o_miss) |-> (o_eng == '0 && o_off == '0 && o_chan == '0 && !o_bcast));
    a_r11_hit_onehot: assert property (@(posedge clk) disable iff (rst)
        (o_vld && !o_miss) |-> ($countones(o_eng) == 1));
endmodule

// File: tb/dma_win_decode_tb.sv
module dma_win_decode_tb;

    typedef struct packed {
        logic [1:0]  cluster;
        logic        die;
        logic        priv;
        logic [4:0]  chan;
        logic [5:0]  eng;
        logic [16:0] off;
        logic        bcast;
        logic        rsvd;
        logic        miss;
    } exp_t;

    typedef struct {
        exp_t  e;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_vld = 1'b0;
    logic [57:0] i_addr = '0;
    logic        o_vld;
    logic [1:0]  o_cluster;
    logic        o_die, o_priv, o_bcast, o_rsvd, o_miss;
    logic [4:0]  o_chan;
    logic [5:0]  o_eng;
    logic [16:0] o_off;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    item_t q[$];
    exp_t  last_exp = '0;

    always #5 clk = ~clk;

    dma_win_decode u_dut (
        .clk(clk), .rst(rst), .i_vld(i_vld), .i_addr(i_addr),
        .o_vld(o_vld), .o_cluster(o_cluster), .o_die(o_die), .o_priv(o_priv),
        .o_chan(o_chan), .o_eng(o_eng), .o_off(o_off), .o_bcast(o_bcast),
        .o_rsvd(o_rsvd), .o_miss(o_miss)
    );

    function automatic exp_t actual();
        return {o_cluster, o_die, o_priv, o_chan, o_eng, o_off, o_bcast, o_rsvd, o_miss};
    endfunction

    // independent model of the requirements, in 64-bit arithmetic
    function automatic exp_t ref_decode(input logic [57:0] a);
        exp_t e = '0;
        longint unsigned loc, rb, ro, go, so, wb;
        int ch, eng;
        bit bc;
        e.die  = a[47];
        e.priv = a[53];
        loc = 64'(a[46:0]);
        rb  = a[38] ? 64'h50_0000_0000 : 64'h10_0000_0000;
        if (loc < rb || loc >= rb + 64'hC80_0000) begin e.miss = 1; return e; end
        ro = loc - rb;
        go = a[38] ? 64'h400_0000 : 64'h200_0000;
        if (ro < go || ro >= go + 64'd32 * 64'h10_0000) begin e.miss = 1; return e; end
        ch = int'((ro - go) >> 20);
        so = (ro - go) & 64'hF_FFFF;
        bc = 0;
        if (so >= 64'h8_0000 && so < 64'hC_0000 && (ch == 0 || ch == 16)) begin
            bc = 1;
            so = so - 64'h8_0000;
        end
        if (!bc && so >= 64'h4_2000 && so < 64'h4_4000) begin
            e.rsvd = 1; e.miss = 1; return e;
        end
        if      (so < 64'h2_0000) begin eng = 0; wb = 64'h0_0000; end
        else if (so < 64'h3_8000) begin eng = 1; wb = 64'h2_0000; end
        else if (so < 64'h3_C000) begin eng = 2; wb = 64'h3_8000; end
        else if (so < 64'h4_0000) begin eng = 3; wb = 64'h3_C000; end
        else if (so < 64'h4_1000) begin eng = 4; wb = 64'h4_0000; end
        else if (so < 64'h4_2000) begin eng = 5; wb = 64'h4_1000; end
        else begin e.miss = 1; return e; end
        e.cluster = {a[47], a[38]};
        e.chan    = 5'(ch);
        e.eng     = 6'(1 << eng);
        e.off     = 17'(so - wb);
        e.bcast   = bc;
        return e;
    endfunction

    function automatic logic [57:0] mk(input bit die, input bit par, input int ch,
                                       input longint unsigned so);
        longint unsigned a;
        a = (par ? 64'h50_0000_0000 : 64'h10_0000_0000)
          + (par ? 64'h400_0000 : 64'h200_0000)
          + 64'(ch) * 64'h10_0000 + so;
        if (die) a = a | (64'd1 << 47);
        return 58'(a);
    endfunction

    task automatic send(input logic [57:0] a, input string req);
        item_t it;
        @(negedge clk);
        i_addr = a;
        i_vld  = 1'b1;
        it.e   = ref_decode(a);
        it.req = req;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        i_vld  = 1'b0;
        i_addr = '1;
    endtask

    task automatic check_exact(input exp_t exp, input string req);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: addr-result actual=%h expected=%h", req, actual(), exp);
        end
    endtask

    // scoreboard monitor: one result per cycle after a strobe, held otherwise
    always @(negedge clk) begin
        if (mon_en) begin
            if (o_vld) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R1: actual=unexpected result expected=no result");
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check_exact(it.e, it.req);
                    last_exp = it.e;
                end
            end else begin
                check_exact(last_exp, "R2 hold while idle");
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1: watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (o_vld !== 1'b0 || actual() !== '0) begin
            errors++;
            $display("FAIL R1: reset actual=%b/%h expected=0/0", o_vld, actual());
        end
        mon_en = 1'b1;

        // R6: channel 5, queue register at 0x6038 in the outbound window
        send(58'h10_0250_6038, "R6 ch5 outbound 0x6038");
        // R6 window edges, even cluster
        send(mk(0, 0, 7, 64'h1_FFFF), "R6 outbound last byte");
        send(mk(0, 0, 7, 64'h2_0000), "R6 inbound first byte");
        send(mk(0, 0, 7, 64'h3_7FFF), "R6 inbound last byte");
        send(mk(0, 0, 7, 64'h3_8000), "R6 general first byte");
        send(mk(0, 0, 31, 64'h3_FFFF), "R6 gen-ext last byte ch31");
        send(mk(0, 0, 2, 64'h4_0000), "R6 app-glue first byte");
        send(mk(0, 0, 2, 64'h4_1FFF), "R6 notification last byte");
        idle();
        idle();
        // R5 odd cluster placement and wrong-parity group
        send(mk(0, 1, 3, 64'h2_0040), "R5 odd cluster inbound");
        send(58'h50_0200_0000, "R5 odd cluster at even group offset");
        send(58'h10_0400_0000, "R5 even cluster past group");
        send(58'h10_0000_0000, "R4 region start below group");
        send(58'h10_0C80_0000, "R4 just past region");
        send(58'h30_0200_0000, "R4 no region");
        // R3 die and privileged bits, attribute bits ignored
        send(mk(1, 0, 9, 64'h3_8004), "R3 die bit set");
        send(mk(1, 1, 9, 64'h3_C010) | (58'd1 << 53), "R3 die and priv");
        send(mk(0, 0, 9, 64'h3_C010) | (58'h1F << 48) | (58'hF << 54), "R3 attribute bits");
        // R7 / R8 holes and unmapped
        send(mk(0, 0, 4, 64'h4_2000), "R7 hole start");
        send(mk(0, 1, 4, 64'h4_3FFF), "R7 hole end");
        send(mk(0, 0, 4, 64'h4_4000), "R8 unmapped start");
        send(mk(0, 0, 4, 64'h7_FFFF), "R8 unmapped end");
        send(mk(0, 0, 0, 64'hC_0000), "R8 above mirror on ch0");
        idle();
        // R9 / R10 mirror
        send(mk(0, 0, 0, 64'h8_0000), "R9 ch0 mirror outbound");
        send(mk(0, 0, 16, 64'hB_8010), "R9 ch16 mirror general");
        send(mk(1, 1, 16, 64'hB_FFFF), "R9 ch16 mirror gen-ext end");
        send(mk(0, 0, 0, 64'hA_0004), "R9 ch0 mirror inbound");
        send(mk(0, 0, 5, 64'h8_0000), "R10 ch5 mirror range");
        send(mk(0, 0, 17, 64'hB_8000), "R10 ch17 mirror range");
        send(mk(0, 0, 0, 64'hC_1000), "R11 miss fields zero");

        // mixed sweep across all windows and channels
        for (int n = 0; n < 400; n++) begin
            longint unsigned so;
            logic [57:0] a;
            so = 64'($urandom_range(0, 20'hF_FFFF));
            a  = mk($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    int'($urandom_range(0, 31)), so);
            a  = a | (58'($urandom_range(0, 1023)) << 48);
            if ($urandom_range(0, 9) == 0) a = a ^ (58'd1 << $urandom_range(25, 46));
            send(a, "R6 sweep");
            if ($urandom_range(0, 7) == 0) idle();
        end
        idle();
        idle();
        idle();
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1: pending actual=%0d expected=0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule